// File: doc/BRIEF.md
# Receiver Margin Scan Controller

This block sequences receiver margin measurements for a serial link. It runs in one of two modes. In the error-rate mode it counts qualified samples and the qualified samples that carry at least one error bit. It stops when either count reaches its ceiling, or when software withdraws the request. In the diagnostic mode it keeps a rolling two-cycle history of the received word and of the error-sample word. That history freezes when a chosen trigger source fires, so software can look at the pattern of errors around the event.

Software drives a six-bit control word. Bit 0 requests an error-rate run and bit 1 arms the diagnostic capture. Bits [5:2] choose the trigger sources. Software polls a four-bit status output, which carries the state code in bits [3:1] and a done flag in bit 0. It then reads the counters or the capture outputs. The analog sampler, the offset settings and the register bus sit outside this block.

Top module: `margin_scan_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to the idle state: status reads 4'b0001, both counters read zero and both capture outputs read zero.
- R2: From idle, a control word with run (bit 0) or arm (bit 1) set moves the block to the clearing state on the next edge.
- R3: The clearing state zeroes both counters. It moves on only once both counters read zero. If run is set it goes to counting, otherwise if arm is set it goes to armed, and run wins when both are set. With neither set it returns to idle.
- R4: In counting, each cycle with qual_pulse high adds one to the sample counter. Each such cycle where any err_bits bit is set also adds one to the error counter.
- R5: When either counter reads all ones, both counters stop changing and the block moves to the finished state.
- R6: Clearing run while counting moves the block to finished. Finished returns to idle once run is low. Both counters hold their values in finished and in idle.
- R7: Status bits [3:1] carry the state code: idle 000, clearing 001, finished 010, counting 011, frozen 100, armed 101. Status bit 0 is high only in idle, finished and frozen.
- R8: Control bits [5:2] select trigger sources. Bit 2 selects qual_pulse, bit 3 the OR of err_bits, bit 4 trig_reg and bit 5 trig_port. In armed, a selected source going high moves the block to frozen, and unselected sources have no effect.
- R9: In armed, clearing arm moves the block to frozen only when control bits [4:2] are all zero. Otherwise the block stays armed.
- R10: Every cycle spent in armed, including the one that leaves it, shifts rx_data and smp_data into the captures: the newer word goes to bits [DATA_W-1:0] and the older word to the upper half. In every other state the captures hold.
- R11: Frozen returns to idle when arm is cleared and stays frozen while arm is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 6 | Control word: run, arm, trigger select [5:2] |
| qual_pulse | input | 1 | Sample qualifier for this cycle |
| err_bits | input | DATA_W | Per-bit error flags for this cycle |
| rx_data | input | DATA_W | Received data word |
| smp_data | input | DATA_W | Error-sample data word |
| trig_reg | input | 1 | Manual trigger from a control register |
| trig_port | input | 1 | Manual trigger from a pin |
| status | output | 4 | State code [3:1] and done flag [0] |
| sample_cnt | output | CNT_W | Saturating qualified-sample count |
| error_cnt | output | CNT_W | Saturating errored-sample count |
| rx_capture | output | HIST_N*DATA_W | Frozen received-data history |
| smp_capture | output | HIST_N*DATA_W | Frozen sample-data history |

## Verification
The bench builds the block with DATA_W=8, CNT_W=4 and HIST_N=2. With a four-bit counter the ceiling is 15, so every error-rate run reaches saturation within a few dozen cycles. This lets the bench sweep qualifier and error spacings, including runs where both counters hit the ceiling together and runs stopped early. The eight-bit words keep the capture pattern small. Each trigger source is then swept at several firing cycles, with the unselected sources toggling, and every output is compared against an arithmetic model on every cycle.

// File: rtl/margin_scan_pkg.sv
// Package: shared state codes and control-word bit positions for the
// margin scan controller. Assumes a six-bit control word.
package margin_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_CLEAR  = 3'b001,
        ST_FINISH = 3'b010,
        ST_COUNT  = 3'b011,
        ST_FROZEN = 3'b100,
        ST_ARMED  = 3'b101
    } scan_state_e;

    localparam int CTRL_W     = 6;
    localparam int RUN_BIT    = 0;
    localparam int ARM_BIT    = 1;
    localparam int TSEL_LO    = 2;
    localparam int TRIG_SRC_N = CTRL_W - TSEL_LO;
endpackage

// File: rtl/scan_trig_sel.sv
// Module: gates each trigger source with its select bit and ORs the
// results into one fire flag. Assumes sources are already synchronous.
module scan_trig_sel #(
    parameter int SRC_N = 4
) (
    input  logic [SRC_N-1:0] sel,
    input  logic [SRC_N-1:0] src,
    output logic             fire
);
    logic [SRC_N-1:0] gated;

    // one AND gate per source
    for (genvar i = 0; i < SRC_N; i++) begin : g_gate
        assign gated[i] = sel[i] & src[i];
    end

    // any selected source fires
    assign fire = |gated;
endmodule

// File: rtl/scan_sat_counters.sv
// Module: the pair of saturating measurement counters. Both freeze as
// soon as either reads all ones. Assumes err_hit is only meaningful
// together with qual.
module scan_sat_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             qual,
    input  logic             err_hit,
    output logic [CNT_W-1:0] smp_cnt,
    output logic [CNT_W-1:0] err_cnt,
    output logic             any_sat,
    output logic             both_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic step;

    // saturation and zero flags seen by the state machine
    assign any_sat   = (smp_cnt == CNT_MAX) || (err_cnt == CNT_MAX);
    assign both_zero = (smp_cnt == '0) && (err_cnt == '0);
    assign step      = en && !any_sat && qual;

    // counter registers: clear, then advance on qualified cycles
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            smp_cnt <= '0;
            err_cnt <= '0;
        end else if (step) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (err_hit) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end

    // R4: errors are counted only on samples, so never exceed them
    a_r4_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= smp_cnt);

    // R5: once saturated, the counters stay frozen until cleared
    a_r5_sat_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sat && !clr) |=> ($stable(smp_cnt) && $stable(err_cnt)));
endmodule

// File: rtl/scan_history.sv
// Module: rolling history of HIST_N words. Slot 0 holds the newest word
// and sits in the low bits of the flat output. Assumes shift is high
// only while the controller is armed.
module scan_history #(
    parameter int W      = 40,
    parameter int HIST_N = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift,
    input  logic [W-1:0]          din,
    output logic [HIST_N*W-1:0]   cap
);
    logic [W-1:0] slot [HIST_N];

    for (genvar k = 0; k < HIST_N; k++) begin : g_slot
        if (k == 0) begin : g_head
            // newest slot loads the incoming word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot[k] <= '0;
                end else if (shift) begin
                    slot[k] <= din;
                end
            end
        end else begin : g_tail
            // older slots take their younger neighbour
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot[k] <= '0;
                end else if (shift) begin
                    slot[k] <= slot[k-1];
                end
            end
        end
        assign cap[k*W +: W] = slot[k];
    end

    // R10: a shift lands the input word in the low slot
    a_r10_newest: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (cap[W-1:0] == $past(din)));

    // R10: without a shift the history holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(cap));
endmodule

// File: rtl/margin_scan_ctrl.sv
// Module: top of the margin scan controller. It holds the two-loop state
// machine (error-rate counting and triggered diagnostic capture) and
// wires in the counters, trigger select and data histories. Assumes all
// inputs are synchronous to clk.
module margin_scan_ctrl
    import margin_scan_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int CNT_W  = 16,
    parameter int HIST_N = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CTRL_W-1:0]          ctrl,
    input  logic                       qual_pulse,
    input  logic [DATA_W-1:0]          err_bits,
    input  logic [DATA_W-1:0]          rx_data,
    input  logic [DATA_W-1:0]          smp_data,
    input  logic                       trig_reg,
    input  logic                       trig_port,
    output logic [3:0]                 status,
    output logic [CNT_W-1:0]           sample_cnt,
    output logic [CNT_W-1:0]           error_cnt,
    output logic [HIST_N*DATA_W-1:0]   rx_capture,
    output logic [HIST_N*DATA_W-1:0]   smp_capture
);
    scan_state_e           state_q, state_d;
    logic                  run, arm, err_any, fire, any_sat, both_zero;
    logic                  cnt_clr, cnt_en, hist_shift, done;
    logic [TRIG_SRC_N-1:0] tsel, tsrc;

    // control word and trigger source decode
    assign run     = ctrl[RUN_BIT];
    assign arm     = ctrl[ARM_BIT];
    assign tsel    = ctrl[CTRL_W-1:TSEL_LO];
    assign err_any = |err_bits;
    assign tsrc    = {trig_port, trig_reg, err_any, qual_pulse};

    scan_trig_sel #(.SRC_N(TRIG_SRC_N)) u_trig (
        .sel  (tsel),
        .src  (tsrc),
        .fire (fire)
    );

    // per-state strobes to the datapath
    assign cnt_clr    = (state_q == ST_CLEAR);
    assign cnt_en     = (state_q == ST_COUNT);
    assign hist_shift = (state_q == ST_ARMED);

    scan_sat_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .en        (cnt_en),
        .qual      (qual_pulse),
        .err_hit   (err_any),
        .smp_cnt   (sample_cnt),
        .err_cnt   (error_cnt),
        .any_sat   (any_sat),
        .both_zero (both_zero)
    );

    scan_history #(.W(DATA_W), .HIST_N(HIST_N)) u_rx_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (hist_shift),
        .din   (rx_data),
        .cap   (rx_capture)
    );

    scan_history #(.W(DATA_W), .HIST_N(HIST_N)) u_smp_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (hist_shift),
        .din   (smp_data),
        .cap   (smp_capture)
    );

    // next-state logic for both measurement loops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run || arm) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (run && both_zero)       state_d = ST_COUNT;
                else if (arm && both_zero)  state_d = ST_ARMED;
                else if (!run && !arm)      state_d = ST_IDLE;
            end
            ST_COUNT: begin
                if (any_sat || !run) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (!run) state_d = ST_IDLE;
            end
            ST_ARMED: begin
                if (fire || (!arm && (tsel[2:0] == 3'b000))) state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!arm) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // status nibble: state code over done flag
    assign done   = (state_q == ST_IDLE) || (state_q == ST_FINISH) || (state_q == ST_FROZEN);
    assign status = {state_q, done};

    // R2: a request from idle always passes through clearing
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && (run || arm)) |=> (state_q == ST_CLEAR));

    // R3: a measurement loop is entered only with zeroed counters
    a_r3_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_COUNT) || (state_q == ST_ARMED)) && ($past(state_q) == ST_CLEAR))
        |-> ((sample_cnt == '0) && (error_cnt == '0)));

    // R6: results stay readable in finished and idle
    a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FINISH) || (state_q == ST_IDLE)) |=> ($stable(sample_cnt) && $stable(error_cnt)));

    // R8: a selected trigger in armed freezes the capture
    a_r8_fire: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED) && fire) |=> (state_q == ST_FROZEN));

    // R9: arm removal with a qualifier, error or register source selected keeps waiting
    a_r9_keep_armed: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED) && !fire && (tsel[2:0] != 3'b000)) |=> (state_q == ST_ARMED));

    // R11: frozen holds its capture while arm stays high
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FROZEN) && arm) |=> ((state_q == ST_FROZEN) && $stable(rx_capture) && $stable(smp_capture)));
endmodule

// File: tb/margin_scan_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: small configuration, every output compared each cycle against
// an arithmetic model written from the requirements.
module margin_scan_ctrl_tb;
    localparam int DW   = 8;
    localparam int CW   = 4;
    localparam int HN   = 2;
    localparam int CAPW = DW * HN;
    localparam int MAXC = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [5:0]      ctrl = '0;
    logic            qual = 1'b0;
    logic [DW-1:0]   err = '0;
    logic [DW-1:0]   rxd = '0;
    logic [DW-1:0]   sxd = '0;
    logic            trig_reg = 1'b0;
    logic            trig_port = 1'b0;
    logic [3:0]      status;
    logic [CW-1:0]   sample_cnt, error_cnt;
    logic [CAPW-1:0] rx_capture, smp_capture;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    logic [2:0]      m_state = 3'b000;
    int              m_s = 0;
    int              m_e = 0;
    logic [CAPW-1:0] m_rx = '0;
    logic [CAPW-1:0] m_sx = '0;

    always #10 clk = ~clk;

    margin_scan_ctrl #(.DATA_W(DW), .CNT_W(CW), .HIST_N(HN)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .qual_pulse  (qual),
        .err_bits    (err),
        .rx_data     (rxd),
        .smp_data    (sxd),
        .trig_reg    (trig_reg),
        .trig_port   (trig_port),
        .status      (status),
        .sample_cnt  (sample_cnt),
        .error_cnt   (error_cnt),
        .rx_capture  (rx_capture),
        .smp_capture (smp_capture)
    );

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // R7: status code and done flag; other outputs under the caller's tag
    task automatic compare_all(input string tag);
        logic done;
        done = (m_state == 3'b000) || (m_state == 3'b010) || (m_state == 3'b100);
        check("R7", "status", 128'(status), 128'({m_state, done}));
        check(tag, "sample_cnt", 128'(sample_cnt), 128'(m_s));
        check(tag, "error_cnt", 128'(error_cnt), 128'(m_e));
        check(tag, "rx_capture", 128'(rx_capture), 128'(m_rx));
        check(tag, "smp_capture", 128'(smp_capture), 128'(m_sx));
    endtask

    // one clock: model the requirements on current inputs, then compare
    task automatic tick(input string tag);
        logic [2:0]      ns;
        int              es, ee;
        logic [CAPW-1:0] rn_x, sn_x;
        logic            sat, zero, fire, rn, am;
        rn   = ctrl[0];
        am   = ctrl[1];
        sat  = (m_s == MAXC) || (m_e == MAXC);
        zero = (m_s == 0) && (m_e == 0);
        fire = |(ctrl[5:2] & {trig_port, trig_reg, |err, qual});
        es = m_s; ee = m_e; rn_x = m_rx; sn_x = m_sx;
        ns = m_state;
        case (m_state)
            3'b000: if (rn || am) ns = 3'b001;
            3'b001: begin
                es = 0; ee = 0;
                if (rn && zero)       ns = 3'b011;
                else if (am && zero)  ns = 3'b101;
                else if (!rn && !am)  ns = 3'b000;
            end
            3'b011: begin
                if (!sat && qual) begin
                    es = es + 1;
                    if (|err) ee = ee + 1;
                end
                if (sat || !rn) ns = 3'b010;
            end
            3'b010: if (!rn) ns = 3'b000;
            3'b101: begin
                rn_x = {m_rx[DW-1:0], rxd};
                sn_x = {m_sx[DW-1:0], sxd};
                if (fire || (!am && ctrl[4:2] == 3'b000)) ns = 3'b100;
            end
            3'b100: if (!am) ns = 3'b000;
            default: ns = 3'b000;
        endcase
        @(posedge clk);
        #1;
        m_state = ns; m_s = es; m_e = ee; m_rx = rn_x; m_sx = sn_x;
        compare_all(tag);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        compare_all("R1");
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: error-rate sweep over qualifier and error spacing
        for (int qp = 1; qp <= 3; qp++) begin
            for (int ep = 1; ep <= 3; ep++) begin
                for (int early = 0; early <= 1; early++) begin
                    ctrl = 6'b000001;
                    for (int cyc = 0; cyc < 60; cyc++) begin
                        qual = (cyc % qp) == 0;
                        err  = ((cyc % ep) == 0) ? DW'(8'h01 << (cyc % 8)) : '0;
                        rxd  = DW'(cyc * 3);
                        sxd  = ~DW'(cyc);
                        if (early == 1 && cyc == 9) ctrl = 6'b000000;
                        tick(early == 1 ? "R6" : "R4 R5");
                    end
                    ctrl = 6'b000000; qual = 1'b0; err = '0;
                    repeat (3) tick("R6");
                end
            end
        end

        // R3: run and arm together favour counting
        ctrl = 6'b000111;
        repeat (6) tick("R3");
        ctrl = 6'b000000;
        repeat (3) tick("R3");

        // R8 R10 R11: each trigger source, several firing cycles, others toggling
        for (int src = 0; src < 4; src++) begin
            for (int k = 4; k <= 8; k++) begin
                ctrl = {4'(1 << src), 2'b10};
                for (int cyc = 0; cyc < 14; cyc++) begin
                    rxd       = DW'(src * 40 + cyc * 7 + 1);
                    sxd       = ~DW'(src * 13 + cyc * 5);
                    qual      = (src == 0) ? (cyc == k) : cyc[0];
                    err       = (src == 1) ? ((cyc == k) ? DW'(8'h80) : '0) : (cyc[0] ? DW'(8'h10) : '0);
                    trig_reg  = (src == 2) ? (cyc == k) : cyc[0];
                    trig_port = (src == 3) ? (cyc == k) : cyc[0];
                    tick("R8 R10");
                end
                qual = 1'b0; err = '0; trig_reg = 1'b0; trig_port = 1'b0;
                repeat (2) tick("R11");
                ctrl = 6'b000000;
                repeat (2) tick("R11");
            end
        end

        // R9: arm removal with no select, qualifier select, port select
        for (int v = 0; v < 3; v++) begin
            logic [3:0] sel;
            sel = (v == 0) ? 4'b0000 : ((v == 1) ? 4'b0001 : 4'b1000);
            ctrl = {sel, 2'b10};
            for (int cyc = 0; cyc < 6; cyc++) begin
                rxd = DW'(cyc + 100); sxd = DW'(cyc + 50);
                tick("R9");
            end
            ctrl = {sel, 2'b00};
            repeat (4) tick("R9");
            qual = 1'b1;
            tick("R9");
            qual = 1'b0;
            repeat (3) tick("R9");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule